// File: doc/BRIEF.md
# Stretchable External Memory Cycle Sequencer

This block runs the external data-memory accesses of a small processor core. The core presents a request: an address, a read or write flag and, for a write, the data. The block then drives an address-valid signal, a read strobe or a write strobe, and the address and write data toward a RAM that several masters may share. The length of each access grows with a 3-bit stretch setting held in a control register. This gives slower shared RAM more time to respond without changing the core.

Read and write accesses follow different timing rules. A read holds the address and the read strobe together for stretch+1 cycles. On the last strobe cycle it captures the returned byte. A write holds the address for stretch+2 cycles and places a shorter write strobe inside that window, so the address is set up before the strobe and held after it. Each access ends with a one-cycle done pulse. While an access is in progress the block reports busy, and the core stalls on that signal.

Top module: `xmem_stretch_seq`

## Requirements
- R1: During and after a synchronous active-low reset, busy, done, address-valid and both strobes are low, and the stretch setting is 1.
- R2: A control write with register address 0x8E loads bits [2:0] of the written byte into the stretch setting S. A control write to any other address leaves S unchanged.
- R3: A read request accepted at a clock edge raises address-valid and the read strobe in the next cycle. Both stay high for exactly S+1 cycles, and the write strobe stays low.
- R4: A write request accepted at a clock edge raises address-valid in the next cycle and holds it for exactly S+2 cycles. The read strobe stays low.
- R5: During a write the strobe lasts max(S,1) cycles. For S=0 it is in the first address-valid cycle. For S≥1 it occupies address-valid cycles 2 through S+1, so one address-valid cycle comes before it and one comes after it.
- R6: S is sampled when a request is accepted. A control write during an access does not change that access's timing, and it takes effect from the next request.
- R7: The read data on the memory data input is captured at the end of the last read-strobe cycle. It appears on the read-data output together with a one-cycle done pulse in the cycle after address-valid falls. Writes also end with this done pulse.
- R8: Busy is high from the cycle after acceptance through the done cycle. A request is accepted only at an edge where busy is low, and requests presented while busy is high are ignored.
- R9: While address-valid is high, the memory address equals the accepted request address and does not change. While the write strobe is high, the memory write data equals the accepted write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_addr | input | 8 | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| req_valid | input | 1 | Access request from the core |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| mem_rdata | input | 8 | Data returned by the RAM |
| mem_addr | output | 16 | Address to the RAM |
| mem_addr_vld | output | 1 | Address-valid qualifier |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data to the RAM |
| rd_data | output | 8 | Captured read data |
| busy | output | 1 | Access in progress, so the core must stall |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before any access. They also assume that the core does not expect a request to be queued while busy is high. The bench is built around both assumptions: it resets for several cycles, and it holds req_valid high through busy periods only on purpose, to show that such requests are dropped. The assertions also assume that mem_rdata is a function of the presented address alone. The bench's RAM model meets this by deriving each returned byte from the address combinationally.

// File: rtl/xmem_pkg.sv
// Package: shared types for the stretchable external memory cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package xmem_pkg;
    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_ACTIVE = 2'd1,
        XS_DONE   = 2'd2
    } xs_state_t;
endpackage

// File: rtl/xmem_cfg_reg.sv
// Module: holds the stretch setting, loaded by a control write to one address.
// Assumes: control writes are single-cycle strobes; only the low SW bits matter.
module xmem_cfg_reg #(
    parameter int                 RAW         = 8,
    parameter int                 SW          = 3,
    parameter logic [RAW-1:0]     CFG_ADDR    = 8'h8E,
    parameter int                 STRETCH_RST = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] addr,
    input  logic [7:0]     wdata,
    output logic [SW-1:0]  stretch
);
    logic [SW-1:0] stretch_q;

    // Load the stretch field on a matching control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stretch_q <= SW'(STRETCH_RST);
        end else if (we && (addr == CFG_ADDR)) begin
            stretch_q <= wdata[SW-1:0];
        end
    end

    assign stretch = stretch_q;
endmodule

// File: rtl/xmem_timer.sv
// Module: access state machine and cycle counter. Latches stretch and direction
// at acceptance and counts through stretch+1 (read) or stretch+2 (write) cycles.
// Assumes: start is only raised while idle (the top gates it).
module xmem_timer
    import xmem_pkg::*;
#(
    parameter int SW = 3,
    localparam int CW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_write,
    input  logic [SW-1:0] stretch,
    output logic          idle,
    output logic          active,
    output logic          done_ph,
    output logic          last,
    output logic [CW-1:0] cnt,
    output logic [SW-1:0] s_lat,
    output logic          wr_lat
);
    xs_state_t     state_q;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] s_q;
    logic          wr_q;
    logic [CW-1:0] end_cnt;

    // Final count value of the address phase for the latched access.
    always_comb begin
        end_cnt = wr_q ? ({1'b0, s_q} + CW'(1)) : {1'b0, s_q};
    end

    // Advance the state machine and the in-phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            cnt_q   <= '0;
            s_q     <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                XS_IDLE: begin
                    if (start) begin
                        state_q <= XS_ACTIVE;
                        cnt_q   <= '0;
                        s_q     <= stretch;
                        wr_q    <= start_write;
                    end
                end
                XS_ACTIVE: begin
                    if (cnt_q == end_cnt) begin
                        state_q <= XS_DONE;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                XS_DONE:  state_q <= XS_IDLE;
                default:  state_q <= XS_IDLE;
            endcase
        end
    end

    assign idle    = (state_q == XS_IDLE);
    assign active  = (state_q == XS_ACTIVE);
    assign done_ph = (state_q == XS_DONE);
    assign last    = active && (cnt_q == end_cnt);
    assign cnt     = cnt_q;
    assign s_lat   = s_q;
    assign wr_lat  = wr_q;
endmodule

// File: rtl/xmem_strobe.sv
// Module: decodes read and write strobes from the counter position.
// Assumes: cnt counts from 0 at the first address-valid cycle.
module xmem_strobe #(
    parameter int SW = 3,
    localparam int CW = SW + 1
) (
    input  logic          active,
    input  logic          wr_lat,
    input  logic [CW-1:0] cnt,
    input  logic [SW-1:0] s_lat,
    output logic          rd_stb,
    output logic          wr_stb
);
    logic in_window;

    // Write window: first cycle for zero stretch, else counts 1..stretch.
    always_comb begin
        if (s_lat == '0) begin
            in_window = (cnt == '0);
        end else begin
            in_window = (cnt != '0) && (cnt <= {1'b0, s_lat});
        end
    end

    assign rd_stb = active && !wr_lat;
    assign wr_stb = active && wr_lat && in_window;
endmodule

// File: rtl/xmem_stretch_seq.sv
// Module: top of the stretchable external memory cycle sequencer.
// Accepts one access at a time, drives address/strobes, captures read data.
// Assumes: mem_rdata is valid by the end of the last read-strobe cycle.
module xmem_stretch_seq #(
    parameter int             AW          = 16,
    parameter int             DW          = 8,
    parameter int             RAW         = 8,
    parameter int             SW          = 3,
    parameter logic [RAW-1:0] CFG_ADDR    = 8'h8E,
    parameter int             STRETCH_RST = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [7:0]     cfg_wdata,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_addr_vld,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [DW-1:0]  mem_wdata,
    output logic [DW-1:0]  rd_data,
    output logic           busy,
    output logic           done
);
    localparam int CW = SW + 1;

    logic [SW-1:0] stretch;
    logic          idle, active, done_ph, last, wr_lat, start;
    logic [CW-1:0] cnt;
    logic [SW-1:0] s_lat;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;

    assign start = req_valid && idle;

    xmem_cfg_reg #(
        .RAW(RAW), .SW(SW), .CFG_ADDR(CFG_ADDR), .STRETCH_RST(STRETCH_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .stretch(stretch)
    );

    xmem_timer #(.SW(SW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
        .stretch(stretch), .idle(idle), .active(active), .done_ph(done_ph),
        .last(last), .cnt(cnt), .s_lat(s_lat), .wr_lat(wr_lat)
    );

    xmem_strobe #(.SW(SW)) u_strobe (
        .active(active), .wr_lat(wr_lat), .cnt(cnt), .s_lat(s_lat),
        .rd_stb(mem_rd), .wr_stb(mem_wr)
    );

    // Latch the request address and data on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture returned data on the final read-strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (last && !wr_lat) begin
            rdata_q <= mem_rdata;
        end
    end

    assign mem_addr     = addr_q;
    assign mem_addr_vld = active;
    assign mem_wdata    = wdata_q;
    assign rd_data      = rdata_q;
    assign busy         = active || done_ph;
    assign done         = done_ph;
endmodule

// File: rtl/xmem_stretch_chk.sv
// Checker: temporal properties of the sequencer's ports, attached by bind.
// Assumes: reset is asserted at least one edge before any access.
module xmem_stretch_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_addr_vld,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_addr_vld && !mem_rd && !mem_wr));

    assert_rd_has_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr_vld);

    assert_wr_has_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr_vld && !mem_rd));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_addr_vld);

    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_vld_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_vld |-> busy);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_vld |=> (!mem_addr_vld || $stable(mem_addr)));
endmodule

bind xmem_stretch_seq xmem_stretch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_addr_vld(mem_addr_vld), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr)
);

// File: tb/xmem_stretch_seq_test.sv
`timescale 1ns/1ps
module xmem_stretch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_addr_vld, mem_rd, mem_wr, busy, done;
    logic [7:0]  mem_wdata, rd_data;

    always #4 clk = ~clk;

    // RAM model: returned byte depends only on the address.
    function automatic logic [7:0] ram_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign mem_rdata = ram_val(mem_addr);

    xmem_stretch_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    int compared = 0;
    int mismatched = 0;
    bit comparing = 0;
    bit finished = 0;
    string phase_tag = "";

    // Behavioural reference: t counts cycles since acceptance (0 = idle).
    int          t_m = 0;
    int          s_cfg = 1;
    int          s_acc = 0;
    bit          w_acc = 0;
    logic [15:0] a_acc = '0;
    logic [7:0]  d_acc = '0;

    function automatic int len_of(input bit w, input int s);
        return w ? s + 2 : s + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            t_m = 0;
            s_cfg = 1;
        end else begin
            if (t_m != 0) begin
                t_m = (t_m == len_of(w_acc, s_acc) + 1) ? 0 : t_m + 1;
            end else if (req_valid) begin
                t_m = 1; s_acc = s_cfg; w_acc = req_write;
                a_acc = req_addr; d_acc = req_wdata;
            end
            if (cfg_we && cfg_addr == 8'h8E) s_cfg = int'(cfg_wdata[2:0]);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s%s at %0t: actual %0h expected %0h", req, phase_tag, $time, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (comparing && !finished) begin
            int  len;
            bit  e_vld, e_rd, e_wr, e_done, e_busy;
            len    = len_of(w_acc, s_acc);
            e_vld  = (t_m >= 1) && (t_m <= len);
            e_rd   = e_vld && !w_acc;
            e_wr   = w_acc && (s_acc == 0 ? t_m == 1 : (t_m >= 2 && t_m <= s_acc + 1));
            e_done = (t_m == len + 1);
            e_busy = (t_m != 0);
            if (!rst_n) begin
                chk("R1 busy", {31'b0, busy}, 0);
                chk("R1 vld", {31'b0, mem_addr_vld}, 0);
                chk("R1 done", {31'b0, done}, 0);
            end else begin
                chk(w_acc ? "R4 addr-valid" : "R3 addr-valid", {31'b0, mem_addr_vld}, {31'b0, e_vld});
                chk("R3 rd strobe", {31'b0, mem_rd}, {31'b0, e_rd});
                chk("R5 wr strobe", {31'b0, mem_wr}, {31'b0, e_wr});
                chk("R7 done", {31'b0, done}, {31'b0, e_done});
                chk("R8 busy", {31'b0, busy}, {31'b0, e_busy});
                if (e_vld) chk("R9 addr", {16'b0, mem_addr}, {16'b0, a_acc});
                if (e_wr)  chk("R9 wdata", {24'b0, mem_wdata}, {24'b0, d_acc});
                if (e_done && !w_acc) chk("R7 rd_data", {24'b0, rd_data}, {24'b0, ram_val(a_acc)});
            end
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (t_m != 0) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        comparing = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: stretch resets to 1, seen through access lengths.
        phase_tag = " (R1 default stretch)";
        access(0, 16'h1234, 8'h00);
        access(1, 16'h2345, 8'hC3);
        // R2, R3, R4, R5: every stretch value, read and write.
        for (int s = 0; s < 8; s++) begin
            phase_tag = " (R2 sweep)";
            cfg_write(8'h8E, 8'hF8 | 8'(s));
            access(0, 16'h0100 + 16'(s * 37), 8'h00);
            access(1, 16'h8000 + 16'(s * 11), 8'(8'hA0 + s));
        end
        // R2: other control addresses leave the stretch alone.
        phase_tag = " (R2 other address)";
        cfg_write(8'h8F, 8'h02);
        cfg_write(8'h0E, 8'h05);
        access(0, 16'hBEEF, 8'h00);
        access(1, 16'hCAFE, 8'h77);
        // R6: change stretch in mid-access.
        phase_tag = " (R6 mid-access change)";
        cfg_write(8'h8E, 8'h05);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4242;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h8E; cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_we = 1'b0;
        while (t_m != 0) @(negedge clk);
        access(1, 16'h4343, 8'h19);
        // R8: requests held while busy are dropped.
        phase_tag = " (R8 held request)";
        cfg_write(8'h8E, 8'h03);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h1111;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_write = ~req_write; req_addr = req_addr + 16'h0101; req_wdata = 8'(i);
        end
        req_valid = 1'b0;
        while (t_m != 0) @(negedge clk);
        // Back-to-back with valid held through done.
        phase_tag = " (R8 back-to-back)";
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h5555; req_wdata = 8'h3C;
        repeat (12) @(negedge clk);
        req_valid = 1'b0;
        while (t_m != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule